// File: doc/BRIEF.md
# Multi-Way Stream Buffer Prefetcher

This block sits beside a first-level data cache and holds prefetched sequential lines in a few small FIFOs, so speculative lines never enter the cache arrays. The cache sends each demand miss to the block. Only the oldest entry of each FIFO is compared against the miss. A match hands that line back to the cache, and the FIFO then requests one more line along its stream. This keeps each stream the same number of lines ahead of the demand.

When no FIFO head matches, the block answers "not held" at once, so the cache fetches the missed line itself. A stream is then started in a FIFO for the lines that follow the missed line. An idle FIFO is taken first. When every FIFO is busy, the one used least recently is flushed and reused. The stream climbs by one line per request. It descends instead when the missed line lies one line below the previous demand miss. Lookups that the cache reports as real cache hits are accepted but cause no action, which filters out needless stream allocation.

Each FIFO holds DEPTH lines of 64 bytes, so its prefetch depth is DEPTH lines. Each FIFO has at most one memory read in flight. Every read carries the FIFO index and a generation count, and a response from a generation that has since been flushed is discarded.

Top module: `sbuf_prefetch`

## Requirements
- R1: After reset, rspValid and memReqValid are 0, reqReady is 1 and no FIFO holds a stream.
- R2: An accepted lookup (reqCacheHit=0) that matches no FIFO head gives rspValid=1 with rspHit=0 on the following cycle. It starts a stream in the lowest-numbered idle FIFO, and that FIFO reads the next DEPTH lines (missed line+1, +2, ...) one at a time, in order.
- R3: A lookup whose line equals a filled FIFO head gives rspValid=1, rspHit=1 and that line's data on the following cycle. The FIFO drops the head and requests exactly one further line of its stream.
- R4: Only heads are compared: a lookup whose line sits in a non-head entry is answered with rspHit=0 and starts a new stream.
- R5: A lookup that matches a head whose memory data has not yet returned holds reqReady at 0 until the data is written. It then completes as a hit carrying that data.
- R6: When all FIFOs hold streams, a non-matching lookup flushes and reuses the least recently used FIFO, where use means an allocation or a head hit. Streams in the other FIFOs are unaffected.
- R7: When the missed line equals the previous accepted lookup's line minus one, the new stream descends (line-1, line-2, ...). Otherwise it ascends.
- R8: A lookup with reqCacheHit=1 is accepted in its cycle, gives no response and starts no stream.
- R9: memReqTag is {FIFO index, 2-bit generation}, and memRspTag echoes it. A response whose generation no longer matches its FIFO is discarded and fills no entry.
- R10: While memReqValid=1 and memReqReady=0, memReqValid, memReqAddr and memReqTag hold steady.
- R11: Addresses are byte addresses with 64-byte lines. The line number is reqAddr[31:6], and memReqAddr always has bits [5:0] at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup from the cache is present |
| reqReady | output | 1 | Lookup accepted this cycle |
| reqAddr | input | 32 | Byte address of the lookup |
| reqCacheHit | input | 1 | Lookup was a cache hit; only filters allocation |
| rspValid | output | 1 | Lookup answer valid |
| rspHit | output | 1 | Line supplied from a FIFO head |
| rspData | output | 64 | Line payload on a hit |
| memReqValid | output | 1 | Memory read request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Line-aligned byte address to read |
| memReqTag | output | 4 | FIFO index and generation |
| memRspValid | input | 1 | Memory read data present |
| memRspTag | input | 4 | Tag of the returning read |
| memRspData | input | 64 | Returned line payload |

## Verification
The assertions assume that memory returns each tag once, and only after the request carrying it was accepted. They also assume that memRspTag never names a FIFO beyond NUM_BUF-1. The bench models memory as an ordered queue that echoes accepted tags after a fixed latency, or later when told to hold its answers. It drops memReqReady on a fixed pattern to exercise the hold rule.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int NUM_BUF    = 4;
  localparam int DEPTH      = 2;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 64;
  localparam int DATA_W     = 64;
  localparam int GEN_W      = 2;
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = ADDR_W - OFS_W;
  localparam int BUF_W      = $clog2(NUM_BUF);
  localparam int TAG_W      = BUF_W + GEN_W;
  localparam int AGE_W      = BUF_W;

  // control -> storage strobes
  typedef struct packed {
    logic [NUM_BUF-1:0] pop;
    logic [NUM_BUF-1:0] flush;
    logic               push;
    logic [BUF_W-1:0]   pushBuf;
    logic [LINE_W-1:0]  pushLine;
    logic               fill;
    logic [BUF_W-1:0]   fillBuf;
    logic [DATA_W-1:0]  fillData;
  } sbStrobe_t;
endpackage

// File: rtl/sbuf_store.sv
module sbuf_store
  import sbuf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  sbStrobe_t                       strobe,
  output logic [NUM_BUF-1:0]              headValid,
  output logic [NUM_BUF-1:0]              headPend,
  output logic [NUM_BUF-1:0][LINE_W-1:0]  headLine,
  output logic [NUM_BUF-1:0][DATA_W-1:0]  headData,
  output logic [NUM_BUF-1:0]              full
);
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    localparam logic [BUF_W-1:0] IDX = BUF_W'(b);
    logic [DEPTH-1:0]             entValid, entPend, vNext, pNext;
    logic [DEPTH-1:0][LINE_W-1:0] entLine, lNext;
    logic [DEPTH-1:0][DATA_W-1:0] entData, dNext;
    logic                         placed;

    always_comb begin
      vNext = entValid; pNext = entPend; lNext = entLine; dNext = entData;
      placed = 1'b0;
      if (strobe.fill && strobe.fillBuf == IDX) begin
        for (int s = 0; s < DEPTH; s++) begin
          if (pNext[s]) begin
            pNext[s] = 1'b0;
            dNext[s] = strobe.fillData;
          end
        end
      end
      if (strobe.pop[b]) begin
        for (int s = 0; s < DEPTH - 1; s++) begin
          vNext[s] = vNext[s+1]; pNext[s] = pNext[s+1];
          lNext[s] = lNext[s+1]; dNext[s] = dNext[s+1];
        end
        vNext[DEPTH-1] = 1'b0;
        pNext[DEPTH-1] = 1'b0;
      end
      if (strobe.push && strobe.pushBuf == IDX) begin
        for (int s = 0; s < DEPTH; s++) begin
          if (!placed && !vNext[s]) begin
            vNext[s] = 1'b1; pNext[s] = 1'b1;
            lNext[s] = strobe.pushLine;
            placed = 1'b1;
          end
        end
      end
      if (strobe.flush[b]) begin
        vNext = '0;
        pNext = '0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid <= '0; entPend <= '0; entLine <= '0; entData <= '0;
      end else begin
        entValid <= vNext; entPend <= pNext; entLine <= lNext; entData <= dNext;
      end
    end

    assign headValid[b] = entValid[0];
    assign headPend[b]  = entPend[0];
    assign headLine[b]  = entLine[0];
    assign headData[b]  = entData[0];
    assign full[b]      = entValid[DEPTH-1];

    // one read in flight per FIFO means at most one waiting entry (R9)
    p_one_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
      $countones(entPend) <= 1);
    p_pend_is_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      (entPend & ~entValid) == '0);
    if (DEPTH > 1) begin : g_pack
      for (genvar s = 0; s < DEPTH - 1; s++) begin : g_slot
        // entries stay packed toward the head, so only slot 0 is compared (R4)
        p_packed_r4: assert property (@(posedge clk) disable iff (!rstN)
          entValid[s+1] |-> entValid[s]);
      end
    end
  end
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  output logic                            reqReady,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic                            reqCacheHit,
  output logic                            rspValid,
  output logic                            rspHit,
  output logic [DATA_W-1:0]               rspData,
  output logic                            memReqValid,
  input  logic                            memReqReady,
  output logic [ADDR_W-1:0]               memReqAddr,
  output logic [TAG_W-1:0]                memReqTag,
  input  logic                            memRspValid,
  input  logic [TAG_W-1:0]                memRspTag,
  input  logic [DATA_W-1:0]               memRspData,
  input  logic [NUM_BUF-1:0]              headValid,
  input  logic [NUM_BUF-1:0]              headPend,
  input  logic [NUM_BUF-1:0][LINE_W-1:0]  headLine,
  input  logic [NUM_BUF-1:0][DATA_W-1:0]  headData,
  input  logic [NUM_BUF-1:0]              full,
  output sbStrobe_t                       strobe
);
  logic [NUM_BUF-1:0]              active, outst, dirBack;
  logic [NUM_BUF-1:0][GEN_W-1:0]   gen;
  logic [NUM_BUF-1:0][LINE_W-1:0]  nextLine;
  logic [NUM_BUF-1:0][AGE_W-1:0]   age;
  logic [LINE_W-1:0]               lastLine, mqLine, lineIn;
  logic                            lastValid, mqValid;
  logic [TAG_W-1:0]                mqTag;

  logic hitAny, freeAny, issueAny, pendHit, accept, doHit, doAlloc;
  logic allocBack, canLoad, load, fillOk, touch;
  logic [BUF_W-1:0] hitIdx, freeIdx, lruIdx, victim, issueIdx, rspBuf, touchIdx;
  logic [GEN_W-1:0] rspGen;
  logic [NUM_BUF-1:0] ageTop;
  logic unusedOfs;

  assign lineIn    = reqAddr[ADDR_W-1:OFS_W];
  assign unusedOfs = ^reqAddr[OFS_W-1:0];
  assign rspBuf    = memRspTag[TAG_W-1:GEN_W];
  assign rspGen    = memRspTag[GEN_W-1:0];

  always_comb begin
    hitAny = 1'b0; hitIdx = '0; freeAny = 1'b0; freeIdx = '0;
    lruIdx = '0; issueAny = 1'b0; issueIdx = '0; ageTop = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (active[b] && headValid[b] && headLine[b] == lineIn) begin
        hitAny = 1'b1; hitIdx = BUF_W'(b);
      end
      if (!active[b]) begin
        freeAny = 1'b1; freeIdx = BUF_W'(b);
      end
      if (age[b] == AGE_W'(NUM_BUF - 1)) begin
        lruIdx = BUF_W'(b); ageTop[b] = 1'b1;
      end
    end
    victim    = freeAny ? freeIdx : lruIdx;
    pendHit   = hitAny && headPend[hitIdx];
    reqReady  = !(reqValid && !reqCacheHit && pendHit);
    accept    = reqValid && !reqCacheHit && !pendHit;
    doHit     = accept && hitAny;
    doAlloc   = accept && !hitAny;
    allocBack = lastValid && (lineIn == lastLine - 1'b1);
    touch     = doHit || doAlloc;
    touchIdx  = doHit ? hitIdx : victim;
    canLoad   = !mqValid || memReqReady;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (active[b] && !outst[b] && !full[b] && !(doAlloc && victim == BUF_W'(b))) begin
        issueAny = 1'b1; issueIdx = BUF_W'(b);
      end
    end
    load   = canLoad && issueAny;
    fillOk = memRspValid && outst[rspBuf] && gen[rspBuf] == rspGen
             && !(doAlloc && victim == rspBuf);

    strobe          = '0;
    strobe.push     = load;
    strobe.pushBuf  = issueIdx;
    strobe.pushLine = nextLine[issueIdx];
    strobe.fill     = fillOk;
    strobe.fillBuf  = rspBuf;
    strobe.fillData = memRspData;
    for (int b = 0; b < NUM_BUF; b++) begin
      strobe.pop[b]   = doHit && hitIdx == BUF_W'(b);
      strobe.flush[b] = doAlloc && victim == BUF_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= '0; outst <= '0; dirBack <= '0; gen <= '0; nextLine <= '0;
      for (int b = 0; b < NUM_BUF; b++) age[b] <= AGE_W'(b);
      lastValid <= 1'b0; lastLine <= '0;
      mqValid <= 1'b0; mqLine <= '0; mqTag <= '0;
      rspValid <= 1'b0; rspHit <= 1'b0; rspData <= '0;
    end else begin
      rspValid <= accept;
      rspHit   <= doHit;
      rspData  <= doHit ? headData[hitIdx] : '0;
      if (accept) begin
        lastValid <= 1'b1;
        lastLine  <= lineIn;
      end
      if (canLoad) begin
        mqValid <= load;
        if (load) begin
          mqLine <= nextLine[issueIdx];
          mqTag  <= {issueIdx, gen[issueIdx]};
        end
      end
      for (int b = 0; b < NUM_BUF; b++) begin
        if (load && issueIdx == BUF_W'(b)) begin
          outst[b]    <= 1'b1;
          nextLine[b] <= dirBack[b] ? nextLine[b] - 1'b1 : nextLine[b] + 1'b1;
        end
        if (fillOk && rspBuf == BUF_W'(b)) outst[b] <= 1'b0;
        if (doAlloc && victim == BUF_W'(b)) begin
          active[b]   <= 1'b1;
          outst[b]    <= 1'b0;
          gen[b]      <= gen[b] + 1'b1;
          dirBack[b]  <= allocBack;
          nextLine[b] <= allocBack ? lineIn - 1'b1 : lineIn + 1'b1;
        end
        if (touch) begin
          if (BUF_W'(b) == touchIdx)      age[b] <= '0;
          else if (age[b] < age[touchIdx]) age[b] <= age[b] + 1'b1;
        end
      end
    end
  end

  assign memReqValid = mqValid;
  assign memReqAddr  = {mqLine, {OFS_W{1'b0}}};
  assign memReqTag   = mqTag;

  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqCacheHit |=> rspValid);
  p_stall_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> !rspValid);
  p_filter_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqCacheHit |-> reqReady);
  p_filter_no_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqCacheHit |=> !rspValid);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqTag));
  p_lru_unique_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ageTop));
endmodule

// File: rtl/sbuf_prefetch.sv
module sbuf_prefetch
  import sbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqCacheHit,
  output logic               rspValid,
  output logic               rspHit,
  output logic [DATA_W-1:0]  rspData,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [TAG_W-1:0]   memReqTag,
  input  logic               memRspValid,
  input  logic [TAG_W-1:0]   memRspTag,
  input  logic [DATA_W-1:0]  memRspData
);
  sbStrobe_t                       strobe;
  logic [NUM_BUF-1:0]              headValid, headPend, full;
  logic [NUM_BUF-1:0][LINE_W-1:0]  headLine;
  logic [NUM_BUF-1:0][DATA_W-1:0]  headData;

  sbuf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqCacheHit(reqCacheHit),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqTag(memReqTag), .memRspValid(memRspValid), .memRspTag(memRspTag),
    .memRspData(memRspData),
    .headValid(headValid), .headPend(headPend), .headLine(headLine),
    .headData(headData), .full(full), .strobe(strobe)
  );

  sbuf_store i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headValid(headValid), .headPend(headPend), .headLine(headLine),
    .headData(headData), .full(full)
  );
endmodule

// File: tb/test_sbuf_prefetch.sv
module test_sbuf_prefetch;
  localparam int LAT = 4;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqCacheHit = 0, memReqReady = 0;
  logic [31:0] reqAddr = 0;
  logic        memRspValid = 0;
  logic [3:0]  memRspTag = 0;
  logic [63:0] memRspData = 0;
  logic        reqReady, rspValid, rspHit, memReqValid;
  logic [63:0] rspData;
  logic [31:0] memReqAddr;
  logic [3:0]  memReqTag;

  int errors = 0, checks = 0, cyc = 0;
  bit memHold = 0;
  logic [31:0] qAddr [0:63];
  logic [3:0]  qTag  [0:63];
  int          qDue  [0:63];
  int qRd = 0, qWr = 0;
  logic [31:0] logAddr [0:255];
  int logCnt = 0, holdViol = 0, misaligned = 0;
  bit prevStall = 0;
  logic [31:0] prevAddr = 0;

  sbuf_prefetch i_sbuf_prefetch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqCacheHit(reqCacheHit), .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqTag(memReqTag), .memRspValid(memRspValid), .memRspTag(memRspTag),
    .memRspData(memRspData)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] lineData(input int line);
    return {32'(line) ^ 32'hA5A5_0000, 32'(line) * 32'd2654435761};
  endfunction

  // memory model: ordered queue with fixed latency, optional hold
  always @(negedge clk) begin
    cyc++;
    if (prevStall && !(memReqValid && memReqAddr == prevAddr)) holdViol++;
    if (qRd != qWr && !memHold && qDue[qRd % 64] <= cyc) begin
      memRspValid = 1; memRspTag = qTag[qRd % 64];
      memRspData = lineData(int'(qAddr[qRd % 64] >> 6));
      qRd++;
    end else memRspValid = 0;
    memReqReady = (cyc % 5) != 3;
    if (rstN && memReqValid && memReqReady) begin
      qAddr[qWr % 64] = memReqAddr; qTag[qWr % 64] = memReqTag; qDue[qWr % 64] = cyc + LAT;
      qWr++;
      logAddr[logCnt] = memReqAddr; logCnt++;
      if (memReqAddr[5:0] != 0) misaligned++;
    end
    prevStall = rstN && memReqValid && !memReqReady;
    prevAddr  = memReqAddr;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input int line, input logic ch, output logic gv, output logic gh,
                        output logic [63:0] gd);
    @(negedge clk); reqValid = 1; reqAddr = (line << 6) | 32'd5; reqCacheHit = ch;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); reqValid = 0; reqCacheHit = 0;
    #1; gv = rspValid; gh = rspHit; gd = rspData;
  endtask

  task automatic expectMiss(input int line, input string req);
    logic v, h; logic [63:0] d;
    access(line, 0, v, h, d);
    chk(v && !h, req, {62'd0, v, h}, 64'd2);
  endtask

  task automatic expectHit(input int line, input string req);
    logic v, h; logic [63:0] d;
    access(line, 0, v, h, d);
    chk(v && h, req, {62'd0, v, h}, 64'd3);
    chk(d == lineData(line), req, d, lineData(line));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, h; logic [63:0] d; int base, stall;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    chk(!rspValid && !memReqValid && reqReady, "R1", {61'd0, rspValid, memReqValid, reqReady}, 64'd1);
    settle(5);
    chk(logCnt == 0, "R1 no stream", 64'(logCnt), 0);

    // R2, R11: miss starts a stream of DEPTH lines
    expectMiss(100, "R2 miss");
    settle(30);
    chk(logCnt == 2, "R2 depth", 64'(logCnt), 2);
    chk(logAddr[0] == 32'(101 * 64) && logAddr[1] == 32'(102 * 64), "R11 aligned lines",
        {logAddr[0], logAddr[1]}, {32'(101 * 64), 32'(102 * 64)});
    // R3: head hit refills by one
    expectHit(101, "R3 hit");
    settle(30);
    chk(logCnt == 3 && logAddr[2] == 32'(103 * 64), "R3 refill", 64'(logAddr[2]), 64'(103 * 64));
    // R4: non-head entry is not a hit
    expectMiss(103, "R4 non-head");
    expectHit(102, "R3 head after refill");
    // R7: descending stream
    expectMiss(500, "R7 setup");
    expectMiss(499, "R7 alloc");
    settle(30);
    expectHit(498, "R7 descend 1");
    expectHit(497, "R7 descend 2");
    settle(20);
    // R6: LRU replacement (least recent is the stream started at 103)
    expectMiss(900, "R6 replace");
    settle(30);
    expectHit(901, "R6 new stream");
    expectHit(501, "R6 other kept");
    expectMiss(104, "R6 old stream flushed");
    settle(30);
    // R8: filtered lookup
    base = logCnt;
    access(2000, 1, v, h, d);
    chk(!v, "R8 no response", 64'(v), 0);
    settle(20);
    chk(logCnt == base, "R8 no stream", 64'(logCnt), 64'(base));
    expectMiss(2001, "R8 nothing allocated");
    settle(30);
    // R5: pending head stalls
    memHold = 1;
    expectMiss(3000, "R5 setup");
    settle(10);
    @(negedge clk); reqValid = 1; reqAddr = (3001 << 6); reqCacheHit = 0;
    stall = 0;
    for (int i = 0; i < 8; i++) begin #1; if (!reqReady) stall++; @(negedge clk); end
    chk(stall == 8, "R5 stall", 64'(stall), 8);
    memHold = 0;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); reqValid = 0; #1;
    chk(rspValid && rspHit, "R5 hit after fill", {62'd0, rspValid, rspHit}, 3);
    chk(rspData == lineData(3001), "R5 data", rspData, lineData(3001));
    settle(30);
    // R9: stale response after flush is discarded
    memHold = 1;
    for (int k = 4; k <= 8; k++) begin
      expectMiss(k * 1000, "R9 setup");
      settle(8);
    end
    memHold = 0;
    settle(40);
    expectHit(8001, "R9 stale dropped");
    settle(10);
    // R10, R11 over the whole run
    chk(holdViol == 0, "R10 request held", 64'(holdViol), 0);
    chk(misaligned == 0, "R11 alignment", 64'(misaligned), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule